// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns transfer requests from a 32-bit processor core into cycles on an external memory and I/O bus. The core offers a request: a word address, the direction, a memory or I/O space select, a data or control class, four byte enables and write data. The sequencer opens each cycle with a one-clock active-low address strobe while the address, byte enables and cycle-type outputs are valid. It then inserts wait states until the device pulls the active-low ready input. One clock after the last ready, it returns read data and a one-clock completion pulse to the core.

A narrow device can answer with the active-low size-16 input together with ready. If the transfer enables bytes in both halves of the word, the sequencer runs a second cycle for the upper half. That cycle enables only the upper byte lanes and places the upper write half on the low data lines. For reads, the two halves are merged into one word.

Another bus master can claim the bus through a hold request. The sequencer grants it only between cycles. While the grant is held, the address, cycle-type and strobe outputs are released. A core-driven lock level is turned into an active-low lock output, and while that output is asserted hold requests are refused.

Top module: `ext_bus_seq`

## Requirements
- R1: A request is taken at a rising edge only while `req_ready` is high. `req_ready` is high in the idle state when no hold is about to be granted. In the clock after acceptance, `bus_ads_n` is low for exactly one clock. During that clock, `bus_addr` equals `req_addr`, `bus_be_n` equals the bitwise inverse of `req_be`, and on writes `bus_dout` equals `req_wdata`.
- R2: During a cycle, `bus_wr` is 1 for a write and 0 for a read, `bus_mio` is 1 for memory and 0 for I/O, and `bus_dc` is 1 for data and 0 for control. `bus_dout_en` is 1 throughout a write cycle and 0 throughout a read cycle.
- R3: After the strobe clock, the sequencer waits while `bus_ready_n` is sampled high at rising edges. During the wait, `rsp_done` stays low and the address, byte enables and cycle-type outputs hold their values.
- R4: `rsp_done` is high for exactly one clock: the clock after the rising edge at which the final `bus_ready_n` low is sampled. For an unsplit read, `rsp_rdata` then equals the `bus_din` sampled at that edge.
- R5: A cycle is split when all of the following hold at the rising edge that ends the first cycle: `bus_size16_n` is sampled low together with `bus_ready_n` low, `req_be[3:2]` is nonzero, and `req_be[1:0]` is nonzero. The split opens a second cycle with a new one-clock strobe at the same address. In that cycle, `bus_be_n[3:2]` equals the inverse of `req_be[3:2]` and `bus_be_n[1:0]` is 2'b11. On writes, `bus_dout[15:0]` and `bus_dout[31:16]` both carry `req_wdata[31:16]`.
- R6: For a split read, `rsp_rdata` is the second cycle's `bus_din[15:0]` in bits 31:16 and the first cycle's `bus_din[15:0]` in bits 15:0. The `bus_din[31:16]` lines are ignored in both cycles.
- R7: A transfer that enables bytes in only one half, or that ends with `bus_size16_n` high, completes in a single cycle.
- R8: When `hold` is high in the idle state and the lock is not set, `hlda` rises one clock later. While `hlda` is high: `bus_oe` is 0, `bus_addr` is 0, `bus_be_n` is all ones, `bus_ads_n` is high, and requests are not taken. `hlda` falls one clock after `hold` is sampled low.
- R9: A hold request that arrives during a cycle is not granted until the cycle completes. `hlda` rises one clock after `rsp_done`.
- R10: `core_lock` is sampled at every idle clock that does not grant hold. `bus_lock_n` is its registered inverse. While `bus_lock_n` is low, hold is refused and requests are still taken. Once `core_lock` drops, hold is granted two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core offers a transfer |
| req_ready | output | 1 | Transfer is taken at this edge |
| req_addr | input | ADDR_W | Word address |
| req_write | input | 1 | 1 write, 0 read |
| req_mem | input | 1 | 1 memory space, 0 I/O space |
| req_data | input | 1 | 1 data transfer, 0 control transfer |
| req_be | input | DATA_W/8 | Byte enables, active high |
| req_wdata | input | DATA_W | Write data |
| core_lock | input | 1 | Core asks to keep the bus locked |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done |
| bus_addr | output | ADDR_W | Bus word address |
| bus_be_n | output | DATA_W/8 | Byte enables, active low |
| bus_wr | output | 1 | Write (1) or read (0) cycle |
| bus_dc | output | 1 | Data (1) or control (0) cycle |
| bus_mio | output | 1 | Memory (1) or I/O (0) cycle |
| bus_ads_n | output | 1 | Address strobe, active low |
| bus_lock_n | output | 1 | Bus lock, active low |
| bus_oe | output | 1 | Output enable for address, type and strobe drivers |
| bus_dout | output | DATA_W | Write data lines |
| bus_dout_en | output | 1 | Enable for write data drivers |
| bus_din | input | DATA_W | Read data lines |
| bus_ready_n | input | 1 | Cycle end, active low |
| bus_size16_n | input | 1 | 16-bit device answer, active low |
| hold | input | 1 | Other master requests the bus |
| hlda | output | 1 | Bus granted to the other master |

## Verification
Two functions can collide in the same clock. A hold request can arrive while a split transfer is still between its two halves, and a hold request can arrive while the lock output is asserted. The bench raises `hold` in the wait state of the first half of a full-word split read. It then requires both halves to run, the merged data to come back, `hlda` to stay low through the done pulse, and `hlda` to rise exactly one clock later. For the lock case, `hold` is held high across an idle stretch and across a further locked transfer. The bench requires that transfer to be taken, and requires the grant to appear only on the second clock after `core_lock` falls.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
   // Sequencer states: idle, strobe clock, wait for ready, bus handed over
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_WAIT = 2'd2,
      ST_HELD = 2'd3
   } ebs_state_e;
endpackage

// File: rtl/ebs_ctrl.sv
module ebs_ctrl
   import ebs_pkg::*;
#(
   parameter int ADDR_W   = 30,
   parameter int DATA_W   = 32,
   parameter int SPLIT_EN = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic                  req_write,
   input  logic                  req_mem,
   input  logic                  req_data,
   input  logic [DATA_W/8-1:0]   req_be,
   input  logic [DATA_W-1:0]     req_wdata,
   input  logic                  core_lock,
   input  logic                  bus_ready_n,
   input  logic                  bus_size16_n,
   input  logic                  hold,
   output logic                  req_ready,
   output ebs_state_e            st_o,
   output logic                  phase_o,
   output logic                  lock_o,
   output logic [ADDR_W-1:0]     cur_addr,
   output logic                  cur_write,
   output logic                  cur_mem,
   output logic                  cur_data,
   output logic [DATA_W/8-1:0]   cur_be,
   output logic [DATA_W-1:0]     cur_wdata,
   output logic                  step_split,
   output logic                  step_last
);
   localparam int BE_W = DATA_W / 8;
   localparam int HBE  = BE_W / 2;

   ebs_state_e          st_q, st_d;
   logic                phase_q;
   logic                lock_q;
   logic [ADDR_W-1:0]   addr_q;
   logic                write_q, mem_q, data_q;
   logic [BE_W-1:0]     be_q;
   logic [DATA_W-1:0]   wdata_q;
   logic                grant_hold;
   logic                accept;
   logic                ready_hit;
   logic                want_split;

   assign grant_hold = hold && !lock_q;
   assign req_ready  = (st_q == ST_IDLE) && !grant_hold;
   assign accept     = req_ready && req_valid;
   assign ready_hit  = (st_q == ST_WAIT) && !bus_ready_n;

   generate
      if (SPLIT_EN != 0) begin : g_split
         assign want_split = !phase_q && !bus_size16_n &&
                             (|be_q[BE_W-1:HBE]) && (|be_q[HBE-1:0]);
      end else begin : g_nosplit
         assign want_split = 1'b0;
      end
   endgenerate

   assign step_split = ready_hit && want_split;
   assign step_last  = ready_hit && !want_split;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: begin
            if (grant_hold)     st_d = ST_HELD;
            else if (req_valid) st_d = ST_ADDR;
         end
         ST_ADDR: st_d = ST_WAIT;
         ST_WAIT: begin
            if (step_split)     st_d = ST_ADDR;
            else if (step_last) st_d = ST_IDLE;
         end
         ST_HELD: if (!hold)    st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         phase_q <= 1'b0;
         lock_q  <= 1'b0;
         addr_q  <= '0;
         write_q <= 1'b0;
         mem_q   <= 1'b0;
         data_q  <= 1'b0;
         be_q    <= '0;
         wdata_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && !grant_hold) lock_q <= core_lock;
         if (accept) begin
            addr_q  <= req_addr;
            write_q <= req_write;
            mem_q   <= req_mem;
            data_q  <= req_data;
            be_q    <= req_be;
            wdata_q <= req_wdata;
         end
         if (step_split)     phase_q <= 1'b1;
         else if (step_last) phase_q <= 1'b0;
      end
   end

   assign st_o      = st_q;
   assign phase_o   = phase_q;
   assign lock_o    = lock_q;
   assign cur_addr  = addr_q;
   assign cur_write = write_q;
   assign cur_mem   = mem_q;
   assign cur_data  = data_q;
   assign cur_be    = be_q;
   assign cur_wdata = wdata_q;

   // R10: the bus is never handed over while the lock register is set
   assert_held_unlocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HELD) |-> !lock_q)
      else $error("bus handed over with lock set");

   // R5: a second half only follows a first half that ended with ready
   assert_second_half_after_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phase_q) |-> $past(!bus_ready_n && !bus_size16_n))
      else $error("second half started without a narrow ready");
endmodule

// File: rtl/ebs_drive.sv
module ebs_drive
   import ebs_pkg::*;
#(
   parameter int ADDR_W = 30,
   parameter int DATA_W = 32
) (
   input  ebs_state_e            st,
   input  logic                  phase,
   input  logic                  lock,
   input  logic [ADDR_W-1:0]     cur_addr,
   input  logic                  cur_write,
   input  logic                  cur_mem,
   input  logic                  cur_data,
   input  logic [DATA_W/8-1:0]   cur_be,
   input  logic [DATA_W-1:0]     cur_wdata,
   output logic [ADDR_W-1:0]     bus_addr,
   output logic [DATA_W/8-1:0]   bus_be_n,
   output logic                  bus_wr,
   output logic                  bus_dc,
   output logic                  bus_mio,
   output logic                  bus_ads_n,
   output logic                  bus_lock_n,
   output logic                  bus_oe,
   output logic [DATA_W-1:0]     bus_dout,
   output logic                  bus_dout_en,
   output logic                  hlda
);
   localparam int BE_W = DATA_W / 8;
   localparam int HBE  = BE_W / 2;
   localparam int HALF = DATA_W / 2;

   logic            held;
   logic [BE_W-1:0] be_on;

   assign held        = (st == ST_HELD);
   assign hlda        = held;
   assign bus_oe      = !held;
   assign bus_ads_n   = (st != ST_ADDR);
   assign bus_lock_n  = !lock;
   assign bus_addr    = held ? '0 : cur_addr;
   assign bus_wr      = !held && cur_write;
   assign bus_dc      = !held && cur_data;
   assign bus_mio     = !held && cur_mem;
   assign bus_dout_en = cur_write && (st == ST_ADDR || st == ST_WAIT);

   // Lower byte lanes are dropped in the second half of a split transfer
   generate
      for (genvar b = 0; b < BE_W; b++) begin : g_lane
         if (b < HBE) begin : g_lo
            assign be_on[b] = cur_be[b] && !phase;
         end else begin : g_hi
            assign be_on[b] = cur_be[b];
         end
      end
   endgenerate

   assign bus_be_n = held ? '1 : ~be_on;

   // In the second half the upper data half is steered onto both halves
   generate
      for (genvar h = 0; h < 2; h++) begin : g_half
         assign bus_dout[h*HALF +: HALF] =
            phase ? cur_wdata[DATA_W-1 -: HALF] : cur_wdata[h*HALF +: HALF];
      end
   endgenerate
endmodule

// File: rtl/ebs_rdmerge.sv
module ebs_rdmerge #(
   parameter int DATA_W   = 32,
   parameter int SPLIT_EN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_split,
   input  logic              step_last,
   input  logic              phase,
   input  logic [DATA_W-1:0] bus_din,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata
);
   localparam int HALF = DATA_W / 2;

   logic              done_q;
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= step_last;
   end

   generate
      if (SPLIT_EN != 0) begin : g_merge
         logic [HALF-1:0] lo_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lo_q    <= '0;
               rdata_q <= '0;
            end else begin
               if (step_split) lo_q <= bus_din[HALF-1:0];
               if (step_last)
                  rdata_q <= phase ? {bus_din[HALF-1:0], lo_q} : bus_din;
            end
         end
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         rdata_q <= '0;
            else if (step_last) rdata_q <= bus_din;
         end
      end
   endgenerate

   assign rsp_done  = done_q;
   assign rsp_rdata = rdata_q;
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
   import ebs_pkg::*;
#(
   parameter int ADDR_W   = 30,
   parameter int DATA_W   = 32,
   parameter int SPLIT_EN = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic                  req_write,
   input  logic                  req_mem,
   input  logic                  req_data,
   input  logic [DATA_W/8-1:0]   req_be,
   input  logic [DATA_W-1:0]     req_wdata,
   input  logic                  core_lock,
   output logic                  rsp_done,
   output logic [DATA_W-1:0]     rsp_rdata,
   output logic [ADDR_W-1:0]     bus_addr,
   output logic [DATA_W/8-1:0]   bus_be_n,
   output logic                  bus_wr,
   output logic                  bus_dc,
   output logic                  bus_mio,
   output logic                  bus_ads_n,
   output logic                  bus_lock_n,
   output logic                  bus_oe,
   output logic [DATA_W-1:0]     bus_dout,
   output logic                  bus_dout_en,
   input  logic [DATA_W-1:0]     bus_din,
   input  logic                  bus_ready_n,
   input  logic                  bus_size16_n,
   input  logic                  hold,
   output logic                  hlda
);
   generate
      if (DATA_W < 16 || (DATA_W % 16) != 0) begin : g_bad_width
         $error("DATA_W must be a positive multiple of 16");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
      if (SPLIT_EN != 0 && SPLIT_EN != 1) begin : g_bad_split
         $error("SPLIT_EN must be 0 or 1");
      end
   endgenerate

   ebs_state_e              st;
   logic                    phase;
   logic                    lock;
   logic [ADDR_W-1:0]       cur_addr;
   logic                    cur_write, cur_mem, cur_data;
   logic [DATA_W/8-1:0]     cur_be;
   logic [DATA_W-1:0]       cur_wdata;
   logic                    step_split, step_last;

   ebs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPLIT_EN(SPLIT_EN)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_mem(req_mem), .req_data(req_data),
      .req_be(req_be), .req_wdata(req_wdata), .core_lock(core_lock),
      .bus_ready_n(bus_ready_n), .bus_size16_n(bus_size16_n), .hold(hold),
      .req_ready(req_ready), .st_o(st), .phase_o(phase), .lock_o(lock),
      .cur_addr(cur_addr), .cur_write(cur_write), .cur_mem(cur_mem),
      .cur_data(cur_data), .cur_be(cur_be), .cur_wdata(cur_wdata),
      .step_split(step_split), .step_last(step_last)
   );

   ebs_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
      .st(st), .phase(phase), .lock(lock), .cur_addr(cur_addr),
      .cur_write(cur_write), .cur_mem(cur_mem), .cur_data(cur_data),
      .cur_be(cur_be), .cur_wdata(cur_wdata), .bus_addr(bus_addr),
      .bus_be_n(bus_be_n), .bus_wr(bus_wr), .bus_dc(bus_dc), .bus_mio(bus_mio),
      .bus_ads_n(bus_ads_n), .bus_lock_n(bus_lock_n), .bus_oe(bus_oe),
      .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .hlda(hlda)
   );

   ebs_rdmerge #(.DATA_W(DATA_W), .SPLIT_EN(SPLIT_EN)) u_rdmerge (
      .clk(clk), .rst_n(rst_n), .step_split(step_split), .step_last(step_last),
      .phase(phase), .bus_din(bus_din), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
   );

   // R1: the strobe never lasts beyond one clock
   assert_strobe_one_clock_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ads_n |=> bus_ads_n)
      else $error("address strobe held for more than one clock");

   // R3: address and cycle type stay put into the wait state
   assert_defs_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ads_n |=> ($stable(bus_addr) && $stable(bus_wr) && $stable(bus_mio) && $stable(bus_dc)))
      else $error("cycle definition changed after strobe");

   // R4: completion follows a sampled ready and lasts one clock
   assert_done_after_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> $past(!bus_ready_n))
      else $error("done without a preceding ready");

   assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done)
      else $error("done pulse longer than one clock");

   // R8: while granted, no strobe and drivers released
   assert_held_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hlda |-> (bus_ads_n && !bus_oe && !bus_dout_en))
      else $error("bus driven while granted away");

   // R10: lock output and grant never coexist
   assert_lock_excludes_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_lock_n |-> !hlda)
      else $error("grant issued while locked");
endmodule

// File: tb/ext_bus_seq_bench.sv
module ext_bus_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 30;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid;
   logic          req_ready;
   logic [AW-1:0] req_addr;
   logic          req_write, req_mem, req_data;
   logic [3:0]    req_be;
   logic [DW-1:0] req_wdata;
   logic          core_lock;
   logic          rsp_done;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] bus_addr;
   logic [3:0]    bus_be_n;
   logic          bus_wr, bus_dc, bus_mio, bus_ads_n, bus_lock_n, bus_oe;
   logic [DW-1:0] bus_dout;
   logic          bus_dout_en;
   logic [DW-1:0] bus_din;
   logic          bus_ready_n, bus_size16_n, hold, hlda;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ext_bus_seq #(.ADDR_W(AW), .DATA_W(DW), .SPLIT_EN(1)) u_ext_bus_seq (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One transfer, driven and judged from negedge to negedge
   task automatic do_xfer(input logic [29:0] a, input logic w, input logic m,
                          input logic dcv, input logic [3:0] be, input logic [31:0] wd,
                          input int waits, input logic b16, input logic [31:0] dev,
                          input logic lk, input logic hold_mid);
      logic  split;
      string t;
      split = b16 && (|be[3:2]) && (|be[1:0]);
      req_valid = 1'b1; req_addr = a; req_write = w; req_mem = m;
      req_data = dcv; req_be = be; req_wdata = wd;
      chk("R1 ready before accept", {31'd0, req_ready}, 32'd1);
      @(negedge clk);
      req_valid = 1'b0;
      for (int ph = 0; ph < 2; ph++) begin
         t = (ph == 0) ? "R1" : "R5";
         chk({t, " strobe low"}, {31'd0, bus_ads_n}, 32'd0);
         chk({t, " address"}, {2'd0, bus_addr}, {2'd0, a});
         chk("R2 cycle type", {29'd0, bus_wr, bus_mio, bus_dc}, {29'd0, w, m, dcv});
         chk({t, " byte enables"}, {28'd0, bus_be_n},
             {28'd0, (ph == 0) ? ~be : ~{be[3:2], 2'b00}});
         chk("R10 lock output", {31'd0, bus_lock_n}, {31'd0, ~lk});
         chk("R2 data driver enable", {31'd0, bus_dout_en}, {31'd0, w});
         if (w) chk({t, " write data"}, bus_dout, (ph == 0) ? wd : {wd[31:16], wd[31:16]});
         @(negedge clk);
         chk("R1 strobe one clock", {31'd0, bus_ads_n}, 32'd1);
         if (hold_mid && ph == 0) hold = 1'b1;
         for (int k = 0; k < waits; k++) begin
            bus_ready_n = 1'b1;
            @(negedge clk);
            chk("R3 no done in wait", {31'd0, rsp_done}, 32'd0);
            chk("R3 address held", {2'd0, bus_addr}, {2'd0, a});
            chk("R3 strobe stays high", {31'd0, bus_ads_n}, 32'd1);
            chk("R9 no grant mid cycle", {31'd0, hlda}, 32'd0);
         end
         bus_ready_n  = 1'b0;
         bus_size16_n = ~b16;
         bus_din = (ph == 1) ? {16'hBEEF, dev[31:16]} :
                   (split ? {16'hDEAD, dev[15:0]} : dev);
         @(negedge clk);
         bus_ready_n = 1'b1; bus_size16_n = 1'b1; bus_din = '0;
         if (!(split && ph == 0)) break;
      end
      chk(split ? "R6 done after second half" :
          (b16 ? "R7 single cycle with size16" : "R4 done pulse"),
          {31'd0, rsp_done}, 32'd1);
      if (!w) chk(split ? "R6 merged read data" : "R4 read data", rsp_rdata, dev);
      if (hold_mid) chk("R9 no grant with done", {31'd0, hlda}, 32'd0);
      @(negedge clk);
      chk("R4 done one clock", {31'd0, rsp_done}, 32'd0);
      if (hold_mid) begin
         chk("R9 grant after done", {31'd0, hlda}, 32'd1);
         hold = 1'b0;
         @(negedge clk);
         chk("R8 grant released", {31'd0, hlda}, 32'd0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL R3 watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
      req_mem = 1'b0; req_data = 1'b0; req_be = '0; req_wdata = '0;
      core_lock = 1'b0; bus_din = '0; bus_ready_n = 1'b1;
      bus_size16_n = 1'b1; hold = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset strobe idle", {31'd0, bus_ads_n}, 32'd1);
      chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
      chk("R4 reset done low", {31'd0, rsp_done}, 32'd0);
      chk("R8 reset no grant", {30'd0, hlda, bus_oe}, 32'd1);
      chk("R10 reset unlocked", {31'd0, bus_lock_n}, 32'd1);
      chk("R1 reset enables off", {28'd0, bus_be_n}, 32'hF);

      // Sweep direction, byte enables, narrow answer and wait count
      for (int w = 0; w < 2; w++) begin
         for (int be = 1; be < 16; be++) begin
            for (int b = 0; b < 2; b++) begin
               do_xfer(30'(32'h0ABC_0000 + be * 16 + w * 4 + b), w[0], be[0], be[2],
                       be[3:0], 32'h1357_9BDF + be * 32'h0001_1111,
                       (be + b) % 3, b[0], 32'hA1B2_C3D4 ^ (be * 32'h0101_0103),
                       1'b0, 1'b0);
            end
         end
      end

      // R8: hold in idle, request ignored while granted
      hold = 1'b1;
      @(negedge clk);
      chk("R8 grant raised", {31'd0, hlda}, 32'd1);
      chk("R8 drivers released", {31'd0, bus_oe}, 32'd0);
      chk("R8 address parked", {2'd0, bus_addr}, 32'd0);
      chk("R8 enables off", {28'd0, bus_be_n}, 32'hF);
      chk("R8 no request taken", {31'd0, req_ready}, 32'd0);
      req_valid = 1'b1; req_addr = 30'h155; req_be = 4'hF;
      @(negedge clk);
      chk("R8 no strobe while granted", {31'd0, bus_ads_n}, 32'd1);
      @(negedge clk);
      chk("R8 no strobe while granted", {31'd0, bus_ads_n}, 32'd1);
      req_valid = 1'b0; hold = 1'b0;
      @(negedge clk);
      chk("R8 grant dropped", {30'd0, hlda, bus_oe}, 32'd1);
      chk("R8 request discarded", {31'd0, bus_ads_n}, 32'd1);

      // R9: hold arriving inside a split read
      do_xfer(30'h0333_4444, 1'b0, 1'b1, 1'b1, 4'hF, 32'h0, 2, 1'b1,
              32'h9876_5432, 1'b0, 1'b1);

      // R10: locked bus refuses hold, grant follows lock release
      core_lock = 1'b1;
      do_xfer(30'h0000_0F0F, 1'b1, 1'b1, 1'b0, 4'h3, 32'hCAFE_F00D, 1, 1'b0,
              32'h0, 1'b1, 1'b0);
      hold = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R10 hold refused", {31'd0, hlda}, 32'd0);
         chk("R10 lock kept", {31'd0, bus_lock_n}, 32'd0);
      end
      do_xfer(30'h0000_0F10, 1'b0, 1'b1, 1'b1, 4'hC, 32'h0, 1, 1'b0,
              32'h5555_AAAA, 1'b1, 1'b0);
      core_lock = 1'b0;
      @(negedge clk);
      chk("R10 lock released", {31'd0, bus_lock_n}, 32'd1);
      chk("R10 no grant yet", {31'd0, hlda}, 32'd0);
      @(negedge clk);
      chk("R10 grant after unlock", {31'd0, hlda}, 32'd1);
      hold = 1'b0;
      @(negedge clk);
      chk("R8 grant dropped", {31'd0, hlda}, 32'd0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule